// File: doc/BRIEF.md
# Operand Address Generator with Segment Selection

This block turns the addressing fields of a decoded instruction into a memory reference for a 16-bit segmented processor. It takes a 2-bit addressing mode, a 3-bit operand selector and a 16-bit displacement, and combines them with eight general register values. The result is a 16-bit offset. In register mode it returns the selected register value instead, with a flag that marks the result as a register operand.

The block then picks one of four segment registers. By default it uses the data segment. It uses the stack segment when the frame base register takes part in the sum. A segment-control field can force any of the four segments in place of that default. The 20-bit physical address is the segment shifted left by four bits plus the offset.

All results are captured in output registers. A decoder drives the fields in one cycle, and the address, segment and register flag are ready after the next rising clock edge.

Top module: `aggen_unit`

## Requirements
- R1: With mode 01 or 10, the offset is the 16-bit sum, wrapping modulo 2^16, of the terms chosen by the selector on register slots (3 = base, 5 = frame base, 6 = source index, 7 = destination index). The terms are: 0 → s3+s6+disp, 1 → s3+s7+disp, 2 → s5+s6+disp, 3 → s5+s7+disp, 4 → s6+disp, 5 → s7+disp, 6 → s5+disp, 7 → s3+disp.
- R2: With mode 00 the offset follows the same table, except for selector 6. There the offset is the displacement alone, and slot 5 is not added.
- R3: With mode 11 the offset is the value of general register slot `sel` (slots 0..7), and `is_reg_q` is 1. In every other mode `is_reg_q` is 0.
- R4: When the segment-control flag (`seg_ctl[2]`) is 0, the segment is the stack segment (segment slot 2) whenever slot 5 takes part in the sum (mode 00 with selector 2 or 3; mode 01 or 10 with selector 2, 3 or 6). In all other cases, including register mode and direct addressing, it is the data segment (segment slot 3).
- R5: When `seg_ctl[2]` is 1, the segment is segment slot `seg_ctl[1:0]` (00 extra, 01 code, 10 stack, 11 data). When `seg_ctl[2]` is 0, the value of `seg_ctl[1:0]` has no effect.
- R6: `phys_q` equals (segment × 16 + offset) truncated to 20 bits, with any carry out of bit 19 dropped.
- R7: Outputs are registered. Inputs present at a rising edge appear on the outputs right after that edge and hold until the next edge. A synchronous active-high reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Addressing mode field |
| sel | input | 3 | Operand selector field |
| disp | input | 16 | Displacement |
| gpr_flat | input | 128 | General register slots, slot i at bits [16i+15:16i] |
| seg_flat | input | 64 | Segment register slots, slot i at bits [16i+15:16i] |
| seg_ctl | input | 3 | Bit 2 forces a segment; bits 1:0 name it |
| offset_q | output | 16 | Registered offset, or register value in mode 11 |
| is_reg_q | output | 1 | Registered register-operand flag |
| seg_q | output | 16 | Registered selected segment value |
| phys_q | output | 20 | Registered physical address |

## Verification
The offset, the register flag, the segment and the physical address are all due on the first rising edge after their inputs are driven. The bench drives inputs on the falling edge and reads every result one time unit after the next rising edge. One check samples just before that edge to confirm that the previous result is still held. The reset check reads the outputs after edges with reset high, while nonzero inputs are applied.

// File: rtl/aggen_pkg.sv
package aggen_pkg;
  localparam int AG_NREG = 8;
  localparam int AG_NSEG = 4;

  localparam logic [1:0] MODE_MEM0 = 2'b00;
  localparam logic [1:0] MODE_REG  = 2'b11;

  localparam int SLOT_BASE  = 3;
  localparam int SLOT_FRAME = 5;
  localparam int SLOT_SRC   = 6;
  localparam int SLOT_DST   = 7;

  localparam logic [1:0] SEG_STACK = 2'd2;
  localparam logic [1:0] SEG_DATA  = 2'd3;

  typedef enum logic [1:0] {BT_NONE, BT_BASE, BT_FRAME} base_term_e;
  typedef enum logic [1:0] {IT_NONE, IT_SRC, IT_DST} idx_term_e;
endpackage

// File: rtl/aggen_offset.sv
module aggen_offset
  import aggen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [1:0]   mode,
  input  logic [2:0]   sel,
  input  logic [W-1:0] disp,
  input  logic [W-1:0] regs [AG_NREG],
  output logic [W-1:0] offset,
  output logic         reg_mode,
  output logic         frame_used
);
  base_term_e  base_k;
  idx_term_e   idx_k;
  logic [W-1:0] base_v, idx_v, mem_sum;

  always_comb begin
    base_k = BT_NONE;
    idx_k  = IT_NONE;
    case (sel)
      3'd0: begin base_k = BT_BASE;  idx_k = IT_SRC; end
      3'd1: begin base_k = BT_BASE;  idx_k = IT_DST; end
      3'd2: begin base_k = BT_FRAME; idx_k = IT_SRC; end
      3'd3: begin base_k = BT_FRAME; idx_k = IT_DST; end
      3'd4: idx_k = IT_SRC;
      3'd5: idx_k = IT_DST;
      3'd6: base_k = (mode == MODE_MEM0) ? BT_NONE : BT_FRAME;
      default: base_k = BT_BASE;
    endcase
  end

  always_comb begin
    case (base_k)
      BT_BASE:  base_v = regs[SLOT_BASE];
      BT_FRAME: base_v = regs[SLOT_FRAME];
      default:  base_v = '0;
    endcase
    case (idx_k)
      IT_SRC:  idx_v = regs[SLOT_SRC];
      IT_DST:  idx_v = regs[SLOT_DST];
      default: idx_v = '0;
    endcase
  end

  assign mem_sum    = base_v + idx_v + disp;
  assign reg_mode   = (mode == MODE_REG);
  assign offset     = reg_mode ? regs[sel] : mem_sum;
  assign frame_used = !reg_mode && (base_k == BT_FRAME);
endmodule

// File: rtl/aggen_segsel.sv
module aggen_segsel
  import aggen_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] segs [AG_NSEG],
  input  logic         frame_used,
  input  logic [2:0]   seg_ctl,
  output logic [W-1:0] seg
);
  logic [1:0] slot;

  always_comb begin
    if (seg_ctl[2]) slot = seg_ctl[1:0];
    else            slot = frame_used ? SEG_STACK : SEG_DATA;
  end

  assign seg = segs[slot];
endmodule

// File: rtl/aggen_phys.sv
module aggen_phys #(
  parameter int W      = 16,
  parameter int SEG_SH = 4,
  parameter int PA_W   = W + SEG_SH
) (
  input  logic [W-1:0]    seg,
  input  logic [W-1:0]    offset,
  output logic [PA_W-1:0] phys
);
  localparam int SUM_W = W + SEG_SH;
  logic [SUM_W-1:0] sum;

  assign sum  = {seg, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, offset};
  assign phys = sum[PA_W-1:0];
endmodule

// File: rtl/aggen_unit.sv
module aggen_unit
  import aggen_pkg::*;
#(
  parameter int W      = 16,
  parameter int SEG_SH = 4,
  parameter int PA_W   = W + SEG_SH
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          mode,
  input  logic [2:0]          sel,
  input  logic [W-1:0]        disp,
  input  logic [AG_NREG*W-1:0] gpr_flat,
  input  logic [AG_NSEG*W-1:0] seg_flat,
  input  logic [2:0]          seg_ctl,
  output logic [W-1:0]        offset_q,
  output logic                is_reg_q,
  output logic [W-1:0]        seg_q,
  output logic [PA_W-1:0]     phys_q
);
  logic [W-1:0]    regs [AG_NREG];
  logic [W-1:0]    segs [AG_NSEG];
  logic [W-1:0]    offset_c, seg_c;
  logic            reg_c, frame_c;
  logic [PA_W-1:0] phys_c;

  for (genvar i = 0; i < AG_NREG; i++) begin : g_reg
    assign regs[i] = gpr_flat[i*W +: W];
  end
  for (genvar j = 0; j < AG_NSEG; j++) begin : g_seg
    assign segs[j] = seg_flat[j*W +: W];
  end

  aggen_offset #(.W(W)) u_off (
    .mode(mode), .sel(sel), .disp(disp), .regs(regs),
    .offset(offset_c), .reg_mode(reg_c), .frame_used(frame_c)
  );

  aggen_segsel #(.W(W)) u_seg (
    .segs(segs), .frame_used(frame_c), .seg_ctl(seg_ctl), .seg(seg_c)
  );

  aggen_phys #(.W(W), .SEG_SH(SEG_SH), .PA_W(PA_W)) u_phys (
    .seg(seg_c), .offset(offset_c), .phys(phys_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q <= '0;
      is_reg_q <= 1'b0;
      seg_q    <= '0;
      phys_q   <= '0;
    end else begin
      offset_q <= offset_c;
      is_reg_q <= reg_c;
      seg_q    <= seg_c;
      phys_q   <= phys_c;
    end
  end

  // R3
  reg_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MODE_REG) |->
      (is_reg_q && offset_q == $past(gpr_flat[sel*W +: W])));

  // R2
  direct_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mode) == MODE_MEM0 && $past(sel) == 3'd6) |->
      (offset_q == $past(disp) && !is_reg_q));

  // R5
  forced_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(seg_ctl[2])) |->
      (seg_q == $past(seg_flat[seg_ctl[1:0]*W +: W])));

  // R4
  frame_seg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(seg_ctl[2]) && $past(mode) != MODE_REG &&
     ($past(sel) == 3'd2 || $past(sel) == 3'd3)) |->
      (seg_q == $past(seg_flat[32'(SEG_STACK)*W +: W])));

  // R6
  phys_sum_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |->
      (phys_q == PA_W'({seg_q, {SEG_SH{1'b0}}} + {{SEG_SH{1'b0}}, offset_q})));
endmodule

// File: tb/aggen_unit_tb.sv
`timescale 1ns/1ps
module aggen_unit_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = '0;
  logic [2:0]   sel = '0;
  logic [15:0]  disp = '0;
  logic [2:0]   seg_ctl = '0;
  logic [15:0]  r [8];
  logic [15:0]  s [4];
  logic [127:0] gpr_flat;
  logic [63:0]  seg_flat;
  logic [15:0]  offset_q, seg_q;
  logic         is_reg_q;
  logic [19:0]  phys_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) gpr_flat[i*16 +: 16] = r[i];
    for (int j = 0; j < 4; j++) seg_flat[j*16 +: 16] = s[j];
  end

  aggen_unit u_dut (
    .clk(clk), .rst(rst), .mode(mode), .sel(sel), .disp(disp),
    .gpr_flat(gpr_flat), .seg_flat(seg_flat), .seg_ctl(seg_ctl),
    .offset_q(offset_q), .is_reg_q(is_reg_q), .seg_q(seg_q), .phys_q(phys_q)
  );

  // entry: {mode[26:25], sel[24:22], seg_ctl[21:19], exp_slot[18:17], exp_reg[16], disp[15:0]}
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 3'd6, 3'b000, 2'd3, 1'b0, 16'h1234},
    {2'd1, 3'd6, 3'b000, 2'd2, 1'b0, 16'h0010},
    {2'd2, 3'd2, 3'b000, 2'd2, 1'b0, 16'h0200},
    {2'd2, 3'd3, 3'b100, 2'd0, 1'b0, 16'h0007},
    {2'd0, 3'd0, 3'b101, 2'd1, 1'b0, 16'h0000},
    {2'd3, 3'd5, 3'b000, 2'd3, 1'b1, 16'h5555},
    {2'd0, 3'd7, 3'b011, 2'd3, 1'b0, 16'h0003},
    {2'd1, 3'd2, 3'b110, 2'd2, 1'b0, 16'hFFFE},
    {2'd2, 3'd4, 3'b111, 2'd3, 1'b0, 16'h8000},
    {2'd0, 3'd3, 3'b010, 2'd2, 1'b0, 16'h0000}
  };

  function automatic logic [15:0] m_off(input logic [1:0] md, input logic [2:0] c,
                                        input logic [15:0] d);
    if (md == 2'b11) return r[c];
    case (c)
      3'd0: return r[3] + r[6] + d;
      3'd1: return r[3] + r[7] + d;
      3'd2: return r[5] + r[6] + d;
      3'd3: return r[5] + r[7] + d;
      3'd4: return r[6] + d;
      3'd5: return r[7] + d;
      3'd6: return (md == 2'b00) ? d : r[5] + d;
      default: return r[3] + d;
    endcase
  endfunction

  function automatic logic [1:0] m_slot(input logic [1:0] md, input logic [2:0] c,
                                        input logic [2:0] ctl);
    logic fr;
    fr = (md != 2'b11) && (c == 3'd2 || c == 3'd3 || (c == 3'd6 && md != 2'b00));
    if (ctl[2]) return ctl[1:0];
    return fr ? 2'd2 : 2'd3;
  endfunction

  function automatic logic [19:0] m_phys(input logic [15:0] sg, input logic [15:0] of);
    return {sg, 4'h0} + {4'h0, of};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] md, input logic [2:0] c, input logic [2:0] ctl,
                       input logic [15:0] d);
    @(negedge clk);
    mode = md; sel = c; seg_ctl = ctl; disp = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_all(input string tag, input logic [1:0] md, input logic [2:0] c,
                           input logic [2:0] ctl, input logic [15:0] d);
    logic [15:0] eo, es;
    eo = m_off(md, c, d);
    es = s[m_slot(md, c, ctl)];
    chk({tag, " R1/R2/R3 offset"}, 32'(offset_q), 32'(eo));
    chk({tag, " R3 is_reg"}, 32'(is_reg_q), 32'(md == 2'b11));
    chk({tag, " R4/R5 segment"}, 32'(seg_q), 32'(es));
    chk({tag, " R6 phys"}, 32'(phys_q), 32'(m_phys(es, eo)));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] prev_off;
    r = '{16'h1111, 16'h2222, 16'h3333, 16'h0400, 16'h5555, 16'h0600, 16'h0070, 16'h0008};
    s = '{16'hE000, 16'hC000, 16'h5000, 16'hD000};
    mode = 2'd2; sel = 3'd0; disp = 16'h0F0F; seg_ctl = 3'b101;

    // R7: reset clears outputs even with nonzero inputs
    repeat (2) @(posedge clk);
    #1;
    chk("R7 reset offset", 32'(offset_q), 0);
    chk("R7 reset seg", 32'(seg_q), 0);
    chk("R7 reset phys", 32'(phys_q), 0);
    chk("R7 reset is_reg", 32'(is_reg_q), 0);
    @(negedge clk);
    rst = 1'b0;

    // Table of directed vectors
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][26:25], VEC[k][24:22], VEC[k][21:19], VEC[k][15:0]);
      check_all($sformatf("vec%0d", k), VEC[k][26:25], VEC[k][24:22],
                VEC[k][21:19], VEC[k][15:0]);
      chk($sformatf("vec%0d R4/R5 table slot", k), 32'(seg_q), 32'(s[VEC[k][18:17]]));
      chk($sformatf("vec%0d R3 table flag", k), 32'(is_reg_q), 32'(VEC[k][16]));
    end

    // R1: 16-bit wrap of the offset sum
    r[3] = 16'hFFF0; r[6] = 16'h0020;
    drive(2'd2, 3'd0, 3'b000, 16'h0001);
    chk("R1 wrap offset", 32'(offset_q), 32'h0011);

    // R6: 20-bit wrap of the physical address
    s[3] = 16'hFFFF; r[6] = 16'h0020;
    drive(2'd0, 3'd4, 3'b000, 16'h0000);
    chk("R6 wrap phys", 32'(phys_q), 32'h00010);

    // R2: direct addressing ignores slot 5, default data segment
    r[5] = 16'hABCD;
    drive(2'd0, 3'd6, 3'b000, 16'h0042);
    chk("R2 direct offset", 32'(offset_q), 32'h0042);
    chk("R4 direct segment", 32'(seg_q), 32'hFFFF);

    // R7: result holds until the next edge
    prev_off = offset_q;
    @(negedge clk);
    mode = 2'd3; sel = 3'd1;
    #1;
    chk("R7 hold before edge", 32'(offset_q), 32'(prev_off));
    @(posedge clk);
    #1;
    chk("R7 update after edge", 32'(offset_q), 32'(r[1]));

    // Sweep all mode/selector pairs with random values
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 8; i++) r[i] = 16'($urandom);
      for (int j = 0; j < 4; j++) s[j] = 16'($urandom);
      for (int m = 0; m < 4; m++) begin
        for (int c = 0; c < 8; c++) begin
          logic [15:0] d;
          logic [2:0]  ctl;
          d   = 16'($urandom);
          ctl = 3'($urandom);
          drive(2'(m), 3'(c), ctl, d);
          check_all($sformatf("sweep m%0d s%0d", m, c), 2'(m), 3'(c), ctl, d);
        end
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule